// File: doc/BRIEF.md
# Reference clock loss supervisor

This block sits in a free-running system clock domain and watches a reference clock for missing edges. It synchronizes the reference, finds its rising edges, and counts system cycles between consecutive edges. From that count it decides what a downstream synthesized clock output should do while the reference is absent and while the loop is re-acquiring lock. It drives an unlock status flag, an enable for the output clock gate and a one-cycle request to restart lock acquisition.

Each outage is sorted into one of four classes by its gap count. The gap count g is the number of system cycles strictly between two consecutive edge detections. A gap up to `MISS_CYC` is normal jitter. A gap above that and up to `SHORT_CYC` is a short outage. A gap below the timeout is a medium outage. A gap at or beyond the timeout `2**TOUT_EXP` is a long outage. A skip-enable bit lets the output ride through short outages without any relock. A second bit chooses whether the output is gated off or passed through, with no guarantee of validity, while unlock is shown. Lock acquisition time is whatever the external lock indication says it is.

Top module: `ref_outage_guard`

## Requirements
- R1: During reset and after it, `unlock_o` is 1, `relock_o` is 0 and `out_en_o` equals `cfg_out_on_unlock_i`. This holds until `lock_i` is sampled high; `unlock_o` is then 0 from the next cycle.
- R2: A rising edge of `ref_clk_i` sampled at clock edge k is acted on at clock edge k+2. A gap with g <= `MISS_CYC` changes none of the outputs.
- R3: If no edge is detected for `2**TOUT_EXP` + 1 cycles after an edge detection, `unlock_o` rises on the following clock edge. It stays high through the outage.
- R4: While `unlock_o` is 0, `out_en_o` is 1. While `unlock_o` is 1, `out_en_o` equals `cfg_out_on_unlock_i`.
- R5: For a medium gap (`SHORT_CYC` < g < `2**TOUT_EXP`), the outputs do not change during the gap. When the edge that ends the gap is detected, `relock_o` and `unlock_o` both go high on the next clock edge.
- R6: For a short gap (`MISS_CYC` < g <= `SHORT_CYC`) with `cfg_skip_en_i` = 1, `unlock_o` and `relock_o` stay 0 through the gap and after it.
- R7: For a short gap with `cfg_skip_en_i` = 0, the output runs during the gap. When the reference returns, the block behaves as in R5.
- R8: After a relock request, `unlock_o` falls on the clock edge after the first cycle in which `lock_i` is high. In the running state `lock_i` has no effect.
- R9: If the edge that ends a gap arrives in the same cycle the counter reaches the timeout (g = `2**TOUT_EXP`), the return edge wins. `unlock_o` does not rise earlier; it rises together with `relock_o`.
- R10: `relock_o` is high for exactly one cycle per returning outage that needs re-acquisition. This covers long gaps, medium gaps and short gaps without skip.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Free-running system clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| ref_clk_i | input | 1 | Reference clock, asynchronous to clk_i |
| lock_i | input | 1 | Lock-achieved indication from the lock detector |
| cfg_skip_en_i | input | 1 | Ride through short outages without relock |
| cfg_out_on_unlock_i | input | 1 | 1 passes the output during unlock, 0 gates it |
| unlock_o | output | 1 | Unlock status flag |
| out_en_o | output | 1 | Enable for the output clock gate |
| relock_o | output | 1 | One-cycle request to re-acquire lock |

## Verification
The return edge of a reference gap and the expiry of the timeout counter can land in the same cycle. The bench provokes this by placing the second reference edge exactly `2**TOUT_EXP` + 1 cycles after the first. It then checks that `unlock_o` stays low until the cycle in which `relock_o` pulses, and that the two rise together. The same sweep steps the gap through every length from 1 to three past the timeout, under all four settings of the two configuration bits. This lands gaps one cycle either side of each class border.

// File: rtl/refguard_pkg.sv
package refguard_pkg;

  typedef enum logic [1:0] {
    GUARD_ACQ  = 2'd0,
    GUARD_RUN  = 2'd1,
    GUARD_LOST = 2'd2
  } guard_state_e;

  typedef enum logic [1:0] {
    GAP_NONE   = 2'd0,
    GAP_SHORT  = 2'd1,
    GAP_MEDIUM = 2'd2,
    GAP_LONG   = 2'd3
  } gap_class_e;

  // Sort a gap count (cycles strictly between two edge detections).
  function automatic gap_class_e classify_gap(input int unsigned gap,
                                              input int unsigned miss_c,
                                              input int unsigned short_c,
                                              input int unsigned tout_c);
    gap_class_e c;
    if (gap >= tout_c)       c = GAP_LONG;
    else if (gap > short_c)  c = GAP_MEDIUM;
    else if (gap > miss_c)   c = GAP_SHORT;
    else                     c = GAP_NONE;
    return c;
  endfunction

  // Whether an ended gap of this class forces a fresh lock acquisition.
  function automatic logic gap_needs_relock(input gap_class_e c, input logic skip_en);
    logic r;
    case (c)
      GAP_LONG, GAP_MEDIUM: r = 1'b1;
      GAP_SHORT:            r = ~skip_en;
      default:              r = 1'b0;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/refguard_edge_sync.sv
module refguard_edge_sync #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ref_i,
  output logic edge_o
);

  logic [SYNC_STAGES-1:0] chain_q;
  logic                   hist_q;

  generate
    for (genvar i = 0; i < SYNC_STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk_i or negedge rst_ni) begin
          if (!rst_ni) chain_q[0] <= 1'b0;
          else         chain_q[0] <= ref_i;
        end
      end else begin : g_next
        always_ff @(posedge clk_i or negedge rst_ni) begin
          if (!rst_ni) chain_q[i] <= 1'b0;
          else         chain_q[i] <= chain_q[i-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) hist_q <= 1'b0;
    else         hist_q <= chain_q[SYNC_STAGES-1];
  end

  assign edge_o = chain_q[SYNC_STAGES-1] & ~hist_q;

endmodule

// File: rtl/refguard_gap_timer.sv
module refguard_gap_timer #(
  parameter int unsigned TOUT_EXP = 23,
  localparam int unsigned CNT_W   = TOUT_EXP + 1,
  localparam int unsigned TIMEOUT = 32'd1 << TOUT_EXP
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             edge_i,
  output logic [CNT_W-1:0] gap_o,
  output logic             timeout_o
);

  localparam logic [CNT_W-1:0] SAT_VAL = CNT_W'(TIMEOUT);

  logic [CNT_W-1:0] cnt_q;
  logic             sat_w;

  assign sat_w = (cnt_q == SAT_VAL);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (edge_i) cnt_q <= '0;
    else if (!sat_w) cnt_q <= cnt_q + 1'b1;
  end

  assign gap_o     = cnt_q;
  assign timeout_o = sat_w;

endmodule

// File: rtl/refguard_ctrl.sv
module refguard_ctrl
  import refguard_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       edge_i,
  input  logic       timeout_i,
  input  gap_class_e gap_class_i,
  input  logic       cfg_skip_i,
  input  logic       cfg_oou_i,
  input  logic       lock_i,
  output logic       unlock_o,
  output logic       out_en_o,
  output logic       relock_o
);

  guard_state_e st_q, st_d;
  logic         relock_d, relock_q;
  logic         needs_w;

  assign needs_w = gap_needs_relock(gap_class_i, cfg_skip_i);

  always_comb begin
    st_d     = st_q;
    relock_d = 1'b0;
    case (st_q)
      GUARD_ACQ: begin
        if (timeout_i && !edge_i) st_d = GUARD_LOST;
        else if (lock_i)          st_d = GUARD_RUN;
      end
      GUARD_RUN: begin
        if (edge_i) begin
          if (needs_w) begin
            st_d     = GUARD_ACQ;
            relock_d = 1'b1;
          end
        end else if (timeout_i) begin
          st_d = GUARD_LOST;
        end
      end
      GUARD_LOST: begin
        if (edge_i) begin
          st_d     = GUARD_ACQ;
          relock_d = 1'b1;
        end
      end
      default: st_d = GUARD_ACQ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q     <= GUARD_ACQ;
      relock_q <= 1'b0;
    end else begin
      st_q     <= st_d;
      relock_q <= relock_d;
    end
  end

  assign unlock_o = (st_q != GUARD_RUN);
  assign out_en_o = (st_q == GUARD_RUN) | cfg_oou_i;
  assign relock_o = relock_q;

endmodule

// File: rtl/ref_outage_guard.sv
module ref_outage_guard
  import refguard_pkg::*;
#(
  parameter int unsigned MISS_CYC    = 16,
  parameter int unsigned SHORT_CYC   = 256,
  parameter int unsigned TOUT_EXP    = 23,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ref_clk_i,
  input  logic lock_i,
  input  logic cfg_skip_en_i,
  input  logic cfg_out_on_unlock_i,
  output logic unlock_o,
  output logic out_en_o,
  output logic relock_o
);

  localparam int unsigned CNT_W   = TOUT_EXP + 1;
  localparam int unsigned TIMEOUT = 32'd1 << TOUT_EXP;

  // Internal events, named for the checker.
  logic             edge_w;
  logic             timeout_w;
  logic [CNT_W-1:0] gap_w;
  gap_class_e       class_w;

  refguard_edge_sync #(.SYNC_STAGES(SYNC_STAGES)) i_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .ref_i  (ref_clk_i),
    .edge_o (edge_w)
  );

  refguard_gap_timer #(.TOUT_EXP(TOUT_EXP)) i_timer (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .edge_i    (edge_w),
    .gap_o     (gap_w),
    .timeout_o (timeout_w)
  );

  assign class_w = classify_gap(32'(gap_w), MISS_CYC, SHORT_CYC, TIMEOUT);

  refguard_ctrl i_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .edge_i      (edge_w),
    .timeout_i   (timeout_w),
    .gap_class_i (class_w),
    .cfg_skip_i  (cfg_skip_en_i),
    .cfg_oou_i   (cfg_out_on_unlock_i),
    .lock_i      (lock_i),
    .unlock_o    (unlock_o),
    .out_en_o    (out_en_o),
    .relock_o    (relock_o)
  );

endmodule

// File: rtl/refguard_chk.sv
module refguard_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic edge_w,
  input logic timeout_w,
  input logic lock_i,
  input logic cfg_oou_i,
  input logic unlock_o,
  input logic out_en_o,
  input logic relock_o
);

  // R10
  relock_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    relock_o |=> !relock_o);

  // R5
  relock_with_unlock_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    relock_o |-> unlock_o);

  // R2
  relock_from_edge_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(relock_o) |-> $past(edge_w));

  // R3
  timeout_unlock_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (timeout_w && !edge_w) |=> unlock_o);

  // R9
  coincide_relock_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (edge_w && timeout_w && !unlock_o) |=> relock_o);

  // R8
  unlock_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(unlock_o) |-> $past(lock_i));

  // R4
  gate_running_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!unlock_o && !$past(unlock_o)) |-> out_en_o);

  // R4
  gate_unlocked_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    unlock_o |-> (out_en_o == cfg_oou_i));

endmodule

bind ref_outage_guard refguard_chk i_refguard_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .edge_w    (edge_w),
  .timeout_w (timeout_w),
  .lock_i    (lock_i),
  .cfg_oou_i (cfg_out_on_unlock_i),
  .unlock_o  (unlock_o),
  .out_en_o  (out_en_o),
  .relock_o  (relock_o)
);

// File: tb/test_ref_outage_guard.sv
module test_ref_outage_guard;

  localparam int MISS  = 5;
  localparam int SHORT = 12;
  localparam int EXP   = 5;
  localparam int TOUT  = 1 << EXP;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ref_clk = 1'b0;
  logic lock = 1'b0;
  logic skip = 1'b0;
  logic oou = 1'b0;
  logic unlock, out_en, relock;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  ref_outage_guard #(
    .MISS_CYC(MISS), .SHORT_CYC(SHORT), .TOUT_EXP(EXP), .SYNC_STAGES(2)
  ) i_ref_outage_guard (
    .clk_i(clk), .rst_ni(rst_n), .ref_clk_i(ref_clk), .lock_i(lock),
    .cfg_skip_en_i(skip), .cfg_out_on_unlock_i(oou),
    .unlock_o(unlock), .out_en_o(out_en), .relock_o(relock)
  );

  task automatic chk(input string req, input string what, input logic act, input logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0b expected=%0b at %0t", req, what, act, exp, $time);
    end
  endtask

  function automatic bit needs_relock(input int g, input bit sk);
    if (g > SHORT)     return 1'b1;
    else if (g > MISS) return !sk;
    return 1'b0;
  endfunction

  function automatic string gap_req(input int g, input bit sk);
    if (g == TOUT)      return "R9";
    else if (g > TOUT)  return "R3";
    else if (g > SHORT) return "R5";
    else if (g > MISS)  return sk ? "R6" : "R7";
    return "R2";
  endfunction

  // Rises spaced four cycles apart (gap 3 <= MISS): normal reference.
  task automatic pump(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); ref_clk = 1'b1;
      @(negedge clk); ref_clk = 1'b0;
      @(negedge clk);
      @(negedge clk);
    end
  endtask

  // Rise A, then rise B after s = g+1 cycles; outputs checked every cycle.
  task automatic run_gap(input int g);
    int s;
    bit nr;
    string rq;
    s  = g + 1;
    nr = needs_relock(g, skip);
    rq = gap_req(g, skip);
    pump(2);
    @(negedge clk); ref_clk = 1'b1;
    for (int j = 1; j <= s + 5; j++) begin
      logic eu, er;
      @(negedge clk);
      eu = ((j >= TOUT + 4) && (j <= s + 2)) || ((j >= s + 3) && (j <= s + 4) && nr);
      er = (j == s + 3) && nr;
      chk((j == s + 5) ? "R8" : rq, "unlock", unlock, eu);
      chk((j == s + 4) ? "R10" : rq, "relock", relock, er);
      chk("R4", "out_en", out_en, eu ? oou : 1'b1);
      if (j == 1 || j == s + 1 || j == s + 5) ref_clk = 1'b0;
      if (j == s || j == s + 4) ref_clk = 1'b1;
      if (j == s + 4) lock = 1'b1;
      if (j == s + 5) lock = 1'b0;
    end
  endtask

  initial begin
    // R1: reset state, gating follows the configuration bit
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      oou = i[0];
      #1;
      chk("R1", "unlock", unlock, 1'b1);
      chk("R1", "relock", relock, 1'b0);
      chk("R1", "out_en", out_en, oou);
    end
    @(negedge clk); rst_n = 1'b1;
    pump(3);
    chk("R1", "unlock", unlock, 1'b1);
    chk("R1", "out_en", out_en, oou);
    @(negedge clk); lock = 1'b1;
    @(negedge clk); lock = 1'b0;
    chk("R1", "unlock", unlock, 1'b0);
    chk("R4", "out_en", out_en, 1'b1);

    for (int c = 0; c < 4; c++) begin
      skip = c[0];
      oou  = c[1];
      for (int g = 1; g <= TOUT + 3; g++) run_gap(g);
    end

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(4 * 150000);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule